// File: doc/BRIEF.md
# Serial Adjustment Register Slave

This block is a two-wire serial bus slave that holds sixteen eight-bit adjustment registers for a display deflection controller. A host writes the registers through one fixed bus address. The first byte after that address picks a register. Each byte after it lands in that register, and the register pointer then moves on by one. The host reads status through a second fixed address. A read needs no register pointer: right after the address is acknowledged the slave sends one byte built from external lock, protection and sync-detection inputs.

All register contents leave the block on one flat output bus, and downstream logic takes its fields from there. Two control bits act as commands and are never kept. A 1 written to either of them gives a one-clock pulse, one for the protection-latch reset and one for the detection refresh. Both bus lines pass through a spike filter before any edge is detected. The slave pulls SDA low only through an open-drain style enable.

Top module: `adj_reg_slave`

## Requirements
- R1: After reset the registers hold: 0:0x80, 1:0x40, 2:0x00, 3:0x90, 4:0x10, 5:0xC0, 6:0x40, 7:0x20, 8:0x20, 9:0xA0, 10:0xC0, 11:0x40, 12:0x00, 13:0xA0, 14:0xA0, 15:0x20. Register i appears on regFlat[8i+7:8i], and SDA is released.
- R2: An address byte of 0x8C (write) or 0x8D (read) is acknowledged by pulling SDA low during the ninth clock. Any other address byte is not acknowledged. The slave then leaves SDA alone and changes no register until the next START.
- R3: In a write, the byte after the address is the register pointer (its low four bits). The next byte is stored in the register it selects. Every byte of an accepted write is acknowledged, and a register changes only when a data byte for it arrives.
- R4: Each further data byte in the same write goes to the register after the previous one.
- R5: The register pointer wraps from 15 back to 0.
- R6: A read returns the status byte MSB first: bit7 horizontal unlock, bit6 vertical unlock, bit5 protection active, bit4 horizontal polarity negative, bit3 vertical polarity negative, bit2 vertical extracted from composite, bit1 horizontal/composite sync present, bit0 vertical sync present. The byte is sampled when the address is decoded and again at each host acknowledge. It repeats while the host acknowledges, and after a host NACK SDA is released.
- R7: Bit 7 of register 1 (protection-latch reset) and bit 7 of register 4 (detection refresh) are never stored and always read as 0. Writing a 1 there gives exactly one high clock on protResetPulse or detRefreshPulse. Writing a 0 gives no pulse.
- R8: A STOP releases SDA and returns the slave to idle. A repeated START in the middle of a write begins a new address phase, and the bytes that follow are treated as a fresh address and pointer.
- R9: A level on SCL or SDA that lasts fewer than FILT_CYCLES clocks is ignored. Such a spike neither shifts a bit nor forms a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |
| hUnlock | input | 1 | Horizontal loop unlocked |
| vUnlock | input | 1 | Vertical section unlocked |
| xrayOn | input | 1 | Protection latch active |
| hPolNeg | input | 1 | Horizontal sync polarity negative |
| vPolNeg | input | 1 | Vertical sync polarity negative |
| vExtDet | input | 1 | Vertical sync extracted from composite input |
| hvDet | input | 1 | Pulses present on horizontal/composite input |
| vDet | input | 1 | Pulses present on vertical input |
| regFlat | output | 128 | All sixteen registers, register i at bits 8i+7:8i |
| protResetPulse | output | 1 | One-clock protection-latch reset command |
| detRefreshPulse | output | 1 | One-clock detection refresh command |

## Verification
A line change at the pins takes two synchroniser stages plus FILT_CYCLES filter clocks to reach the filtered level. A register write, a command pulse and the start of an acknowledge therefore all occur on the (FILT_CYCLES+3)-th rising clock edge after SCL falls at the end of the eighth bit. The bench's model updates its expected register file and pulse count at that SCL fall. It then suspends its every-clock register comparison for two quarter bit periods, which covers that latency with margin, and compares every clock after that. Acknowledge and read bits are sampled one quarter period after SCL rises, when the slave's drive, set at the preceding SCL fall, has long settled.

// File: rtl/adj_reg_pkg.sv
package adj_reg_pkg;

  localparam int NUM_REGS    = 16;
  localparam int SUB_W       = $clog2(NUM_REGS);
  localparam int BYTE_W      = 8;
  localparam int PROT_REG    = 1;
  localparam int REFRESH_REG = 4;
  localparam int CMD_BIT     = 7;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA,
    PH_TX,
    PH_IGNORE
  } phase_e;

  // strobes from bus control to the register datapath
  typedef struct packed {
    logic              loadSub;
    logic              writeData;
    logic              latchStatus;
    logic [BYTE_W-1:0] rxByte;
  } strobe_t;

  // power-up value of each register: drive on, widest duty end, mid-scale corrections
  function automatic logic [BYTE_W-1:0] resetValue(input int idx);
    case (idx)
      0:       return 8'h80;
      1:       return 8'h40;
      3:       return 8'h90;
      4:       return 8'h10;
      5:       return 8'hC0;
      6:       return 8'h40;
      7:       return 8'h20;
      8:       return 8'h20;
      9:       return 8'hA0;
      10:      return 8'hC0;
      11:      return 8'h40;
      13:      return 8'hA0;
      14:      return 8'hA0;
      15:      return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  // command bits are never kept in storage
  function automatic logic [BYTE_W-1:0] storeMask(input int idx);
    logic [BYTE_W-1:0] m;
    m = '1;
    if (idx == PROT_REG || idx == REFRESH_REG) m[CMD_BIT] = 1'b0;
    return m;
  endfunction

endpackage

// File: rtl/adj_spike_filt.sv
module adj_spike_filt #(
  parameter int FILT_CYCLES = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);

  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(FILT_CYCLES - 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      cnt      <= '0;
      cleanOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == cleanOut) begin
        cnt <= '0;
      end else if (cnt == LIM) begin
        cleanOut <= syncQ[1];
        cnt      <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/adj_bus_ctrl.sv
module adj_bus_ctrl
  import adj_reg_pkg::*;
#(
  parameter logic [7:0] WR_ADDR = 8'h8C,
  parameter logic [7:0] RD_ADDR = 8'h8D
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclF,
  input  logic        sdaF,
  input  logic [7:0]  statByte,
  output strobe_t     stb,
  output logic        sdaLow
);

  logic   sclQ, sdaQ;
  logic   sclRise, sclFall, startDet, stopDet;
  phase_e phase;
  logic [3:0] bitCnt;
  logic [7:0] shReg;
  logic   byteDone, inRx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
    end
  end

  assign sclRise  = sclF & ~sclQ;
  assign sclFall  = ~sclF & sclQ;
  assign startDet = sclF & sclQ & sdaQ & ~sdaF;
  assign stopDet  = sclF & sclQ & ~sdaQ & sdaF;

  assign inRx     = (phase == PH_ADDR) || (phase == PH_SUB) || (phase == PH_DATA);
  assign byteDone = inRx && sclFall && (bitCnt == 4'd8) && !startDet && !stopDet;

  always_comb begin
    stb             = '0;
    stb.rxByte      = shReg;
    stb.loadSub     = byteDone && (phase == PH_SUB);
    stb.writeData   = byteDone && (phase == PH_DATA);
    stb.latchStatus = (byteDone && (phase == PH_ADDR) && (shReg == RD_ADDR)) ||
                      ((phase == PH_TX) && sclRise && (bitCnt == 4'd8) && !sdaF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      shReg  <= '0;
      sdaLow <= 1'b0;
    end else if (startDet) begin
      phase  <= PH_ADDR;
      bitCnt <= '0;
      sdaLow <= 1'b0;
    end else if (stopDet) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      sdaLow <= 1'b0;
    end else begin
      case (phase)
        PH_ADDR, PH_SUB, PH_DATA: begin
          if (sclRise && bitCnt < 4'd8) begin
            shReg  <= {shReg[6:0], sdaF};
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            if (phase == PH_ADDR && shReg != WR_ADDR && shReg != RD_ADDR) begin
              phase <= PH_IGNORE;
            end else begin
              sdaLow <= 1'b1;
              bitCnt <= 4'd9;
              if (phase == PH_ADDR) phase <= (shReg == WR_ADDR) ? PH_SUB : PH_TX;
              else if (phase == PH_SUB) phase <= PH_DATA;
            end
          end else if (sclFall && bitCnt == 4'd9) begin
            sdaLow <= 1'b0;
            bitCnt <= '0;
          end
        end
        PH_TX: begin
          if (sclFall && bitCnt == 4'd9) begin
            shReg  <= statByte;
            sdaLow <= ~statByte[7];
            bitCnt <= '0;
          end else if (sclRise && bitCnt < 4'd8) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            sdaLow <= 1'b0;
          end else if (sclFall && bitCnt < 4'd8) begin
            shReg  <= {shReg[6:0], 1'b0};
            sdaLow <= ~shReg[6];
          end else if (sclRise && bitCnt == 4'd8) begin
            if (sdaF) phase <= PH_IGNORE;
            else      bitCnt <= 4'd9;
          end
        end
        default: ;
      endcase
    end
  end

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!sdaLow && phase == PH_IDLE)); // R8
  AST_QUIET_UNADDRESSED: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE || phase == PH_IGNORE) |-> !sdaLow); // R2

endmodule

// File: rtl/adj_reg_file.sv
module adj_reg_file
  import adj_reg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      stb,
  input  logic [7:0]                   statIn,
  output logic [7:0]                   statByte,
  output logic [NUM_REGS*BYTE_W-1:0]   regFlat,
  output logic                         protPulse,
  output logic                         refreshPulse
);

  localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(NUM_REGS - 1);

  logic [SUB_W-1:0] subAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subAddr <= '0;
    end else if (stb.loadSub) begin
      subAddr <= stb.rxByte[SUB_W-1:0];
    end else if (stb.writeData) begin
      subAddr <= subAddr + SUB_W'(1);
    end
  end

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= resetValue(gi);
      end else if (stb.writeData && subAddr == SUB_W'(gi)) begin
        q <= stb.rxByte & storeMask(gi);
      end
    end
    assign regFlat[gi*BYTE_W +: BYTE_W] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protPulse    <= 1'b0;
      refreshPulse <= 1'b0;
      statByte     <= '0;
    end else begin
      protPulse    <= stb.writeData && subAddr == SUB_W'(PROT_REG) && stb.rxByte[CMD_BIT];
      refreshPulse <= stb.writeData && subAddr == SUB_W'(REFRESH_REG) && stb.rxByte[CMD_BIT];
      if (stb.latchStatus) statByte <= statIn;
    end
  end

  AST_SUB_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeData && subAddr == LAST_SUB) |=> subAddr == '0); // R5
  AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeData && !stb.loadSub) |=> subAddr == $past(subAddr) + SUB_W'(1)); // R4
  AST_PROT_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    protPulse |=> !protPulse); // R7
  AST_REFRESH_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    refreshPulse |=> !refreshPulse); // R7
  AST_HOLD_WITHOUT_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !stb.writeData |=> $stable(regFlat)); // R3

endmodule

// File: rtl/adj_reg_slave.sv
module adj_reg_slave
  import adj_reg_pkg::*;
#(
  parameter int         FILT_CYCLES = 100,
  parameter logic [7:0] WR_ADDR     = 8'h8C,
  parameter logic [7:0] RD_ADDR     = 8'h8D
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  output logic         sdaDriveLow,
  input  logic         hUnlock,
  input  logic         vUnlock,
  input  logic         xrayOn,
  input  logic         hPolNeg,
  input  logic         vPolNeg,
  input  logic         vExtDet,
  input  logic         hvDet,
  input  logic         vDet,
  output logic [127:0] regFlat,
  output logic         protResetPulse,
  output logic         detRefreshPulse
);

  logic [1:0] rawLines, cleanLines;
  strobe_t    stb;
  logic [7:0] statByte, statIn;

  assign rawLines = {sclIn, sdaIn};
  assign statIn   = {hUnlock, vUnlock, xrayOn, hPolNeg, vPolNeg, vExtDet, hvDet, vDet};

  for (genvar gl = 0; gl < 2; gl++) begin : g_filt
    adj_spike_filt #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .rawIn    (rawLines[gl]),
      .cleanOut (cleanLines[gl])
    );
  end

  adj_bus_ctrl #(.WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclF     (cleanLines[1]),
    .sdaF     (cleanLines[0]),
    .statByte (statByte),
    .stb      (stb),
    .sdaLow   (sdaDriveLow)
  );

  adj_reg_file u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .statIn       (statIn),
    .statByte     (statByte),
    .regFlat      (regFlat),
    .protPulse    (protResetPulse),
    .refreshPulse (detRefreshPulse)
  );

endmodule

// File: tb/adj_reg_slave_bench.sv
`timescale 1ns/1ps
module adj_reg_slave_bench;

  localparam int FILT = 4;
  localparam int Q    = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic hUnlock = 0, vUnlock = 0, xrayOn = 0, hPolNeg = 0, vPolNeg = 0;
  logic vExtDet = 0, hvDet = 0, vDet = 0;
  logic sdaDriveLow, protResetPulse, detRefreshPulse;
  logic [127:0] regFlat;
  logic sdaLine;

  always #2.5 clk = ~clk;
  assign sdaLine = mSda & ~sdaDriveLow;

  adj_reg_slave #(.FILT_CYCLES(FILT)) u_adj_reg_slave (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(mSda), .sdaDriveLow(sdaDriveLow),
    .hUnlock(hUnlock), .vUnlock(vUnlock), .xrayOn(xrayOn), .hPolNeg(hPolNeg),
    .vPolNeg(vPolNeg), .vExtDet(vExtDet), .hvDet(hvDet), .vDet(vDet),
    .regFlat(regFlat), .protResetPulse(protResetPulse), .detRefreshPulse(detRefreshPulse)
  );

  int nCmpA = 0, nBadA = 0, nCmpB = 0, nBadB = 0;
  int cycleCnt = 0, holdUntil = 0, protHigh = 0, refHigh = 0;
  int expProt = 0, expRef = 0, expSub = 0;
  bit cmpOn = 0, wdFail = 0, done = 0;
  logic [7:0] expRegs [16];

  function automatic logic [7:0] benchReset(input int i);
    logic [7:0] t [16] = '{8'h80, 8'h40, 8'h00, 8'h90, 8'h10, 8'hC0, 8'h40, 8'h20,
                           8'h20, 8'hA0, 8'hC0, 8'h40, 8'h00, 8'hA0, 8'hA0, 8'h20};
    return t[i];
  endfunction

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // every-clock comparison of the register file against the model
  always @(negedge clk) begin
    if (protResetPulse) protHigh++;
    if (detRefreshPulse) refHigh++;
    if (cmpOn && !done && cycleCnt >= holdUntil) begin
      for (int i = 0; i < 16; i++) begin
        nCmpB++;
        if (regFlat[i*8 +: 8] !== expRegs[i]) begin
          nBadB++;
          $display("FAIL R3 reg %0d act=%0h exp=%0h cycle %0d", i, regFlat[i*8 +: 8], expRegs[i], cycleCnt);
        end
      end
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             nCmpA + nCmpB + int'(wdFail), nBadA + nBadB + int'(wdFail));
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmpA++;
    if (!ok) begin
      nBadA++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mScl = 0; waitCyc(Q); mSda = 1; waitCyc(Q);
    mScl = 1; waitCyc(2*Q); mSda = 0; waitCyc(2*Q);
  endtask

  task automatic busStop();
    mScl = 0; waitCyc(Q); mSda = 0; waitCyc(Q);
    mScl = 1; waitCyc(2*Q); mSda = 1; waitCyc(2*Q);
  endtask

  // glitchMode 1: short SCL high in a low phase; 2: short SDA low inside SCL high of 1-bits
  task automatic sendByte(input logic [7:0] b, input bit commit, input int glitchMode, output bit acked);
    logic [7:0] keep;
    for (int i = 7; i >= 0; i--) begin
      mScl = 0; waitCyc(Q); mSda = b[i];
      if (glitchMode == 1 && i == 4) begin mScl = 1; waitCyc(FILT-2); mScl = 0; end
      waitCyc(Q); mScl = 1;
      if (glitchMode == 2 && b[i]) begin
        waitCyc(Q/2); mSda = 0; waitCyc(FILT-2); mSda = 1; waitCyc(2*Q - Q/2 - (FILT-2));
      end else waitCyc(2*Q);
    end
    mScl = 0;
    if (commit) begin
      keep = b;
      if (expSub == 1 || expSub == 4) begin
        if (b[7]) begin if (expSub == 1) expProt++; else expRef++; end
        keep[7] = 1'b0;
      end
      expRegs[expSub] = keep;
      expSub = (expSub + 1) % 16;
      holdUntil = cycleCnt + 2*Q;
    end
    waitCyc(Q); mSda = 1; waitCyc(Q); mScl = 1; waitCyc(Q);
    acked = (sdaLine == 1'b0);
    waitCyc(Q);
  endtask

  task automatic readByte(output logic [7:0] b, input bit mAck);
    for (int i = 7; i >= 0; i--) begin
      mScl = 0; waitCyc(Q); mSda = 1; waitCyc(Q); mScl = 1; waitCyc(Q);
      b[i] = sdaLine; waitCyc(Q);
    end
    mScl = 0; waitCyc(Q); mSda = mAck ? 1'b0 : 1'b1; waitCyc(Q); mScl = 1; waitCyc(2*Q);
  endtask

  task automatic writeTxn(input logic [7:0] sub, input logic [7:0] d[$], input string tag);
    bit ack;
    busStart();
    sendByte(8'h8C, 0, 0, ack); chk(ack, {"R2 write address ack ", tag}, ack, 1);
    sendByte(sub, 0, 0, ack);   chk(ack, {"R3 pointer ack ", tag}, ack, 1);
    expSub = int'(sub[3:0]);
    foreach (d[k]) begin
      sendByte(d[k], 1, 0, ack); chk(ack, {"R3 data ack ", tag}, ack, 1);
    end
    busStop();
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      wdFail = 1;
      $display("FAIL R3 watchdog act=%0d exp=%0d", cycleCnt, 0);
      report();
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    logic [7:0] stat;
    for (int i = 0; i < 16; i++) expRegs[i] = benchReset(i);
    waitCyc(10); rstN = 1; waitCyc(5);

    // R1 reset state
    for (int i = 0; i < 16; i++)
      chk(regFlat[i*8 +: 8] == benchReset(i), "R1 reset value", regFlat[i*8 +: 8], benchReset(i));
    chk(sdaDriveLow == 0, "R1 SDA released", sdaDriveLow, 0);
    cmpOn = 1;

    // R3 single write
    writeTxn(8'h05, '{8'h3A}, "single");
    chk(regFlat[5*8 +: 8] == 8'h3A, "R3 register 5", regFlat[5*8 +: 8], 8'h3A);

    // R4 burst with R5 wrap
    writeTxn(8'h0D, '{8'h11, 8'h22, 8'h33, 8'h44}, "burst");
    chk(regFlat[13*8 +: 8] == 8'h11, "R4 register 13", regFlat[13*8 +: 8], 8'h11);
    chk(regFlat[15*8 +: 8] == 8'h33, "R4 register 15", regFlat[15*8 +: 8], 8'h33);
    chk(regFlat[0 +: 8] == 8'h44, "R5 wrap to register 0", regFlat[0 +: 8], 8'h44);

    // R7 command bits
    writeTxn(8'h01, '{8'hC5}, "prot");
    chk(regFlat[1*8 +: 8] == 8'h45, "R7 protection bit not kept", regFlat[1*8 +: 8], 8'h45);
    chk(protHigh == expProt && expProt == 1, "R7 protection pulse width", protHigh, 1);
    writeTxn(8'h04, '{8'h00}, "refresh0");
    chk(refHigh == 0, "R7 no refresh pulse on 0", refHigh, 0);
    writeTxn(8'h04, '{8'h9F}, "refresh1");
    chk(refHigh == expRef && expRef == 1, "R7 refresh pulse width", refHigh, 1);
    chk(regFlat[4*8 +: 8] == 8'h1F, "R7 refresh bit not kept", regFlat[4*8 +: 8], 8'h1F);

    // R2 foreign address
    busStart();
    sendByte(8'h50, 0, 0, ack); chk(!ack, "R2 foreign address nack", ack, 0);
    sendByte(8'h07, 0, 0, ack); chk(!ack, "R2 ignored byte nack", ack, 0);
    sendByte(8'h77, 0, 0, ack); chk(!ack, "R2 ignored byte nack", ack, 0);
    busStop();
    chk(regFlat[7*8 +: 8] == 8'h20, "R2 register 7 untouched", regFlat[7*8 +: 8], 8'h20);

    // R6 status reads
    {hUnlock, vUnlock, xrayOn, hPolNeg, vPolNeg, vExtDet, hvDet, vDet} = 8'b1010_0110;
    busStart();
    sendByte(8'h8D, 0, 0, ack); chk(ack, "R2 read address ack", ack, 1);
    readByte(rb, 0); chk(rb == 8'hA6, "R6 status byte", rb, 8'hA6);
    waitCyc(Q);
    chk(sdaDriveLow == 0, "R6 released after nack", sdaDriveLow, 0);
    busStop();
    stat = 8'b0101_1001;
    {hUnlock, vUnlock, xrayOn, hPolNeg, vPolNeg, vExtDet, hvDet, vDet} = stat;
    busStart();
    sendByte(8'h8D, 0, 0, ack); chk(ack, "R2 read address ack", ack, 1);
    readByte(rb, 1); chk(rb == stat, "R6 first status byte", rb, stat);
    readByte(rb, 0); chk(rb == stat, "R6 repeated status byte", rb, stat);
    busStop();

    // R8 repeated start and stop
    busStart();
    sendByte(8'h8C, 0, 0, ack); sendByte(8'h02, 0, 0, ack); expSub = 2;
    sendByte(8'h11, 1, 0, ack);
    busStart();
    sendByte(8'h8C, 0, 0, ack); chk(ack, "R8 address after repeated start", ack, 1);
    sendByte(8'h03, 0, 0, ack); expSub = 3;
    sendByte(8'h22, 1, 0, ack);
    busStop();
    chk(regFlat[2*8 +: 8] == 8'h11, "R8 register 2", regFlat[2*8 +: 8], 8'h11);
    chk(regFlat[3*8 +: 8] == 8'h22, "R8 pointer from new phase", regFlat[3*8 +: 8], 8'h22);
    chk(sdaDriveLow == 0, "R8 released after stop", sdaDriveLow, 0);

    // R9 spikes on both lines
    busStart();
    sendByte(8'h8C, 0, 0, ack); sendByte(8'h06, 0, 0, ack); expSub = 6;
    sendByte(8'h5B, 1, 1, ack); chk(ack, "R9 ack with clock spike", ack, 1);
    sendByte(8'h6D, 1, 2, ack); chk(ack, "R9 ack with data spike", ack, 1);
    busStop();
    chk(regFlat[6*8 +: 8] == 8'h5B, "R9 clock spike ignored", regFlat[6*8 +: 8], 8'h5B);
    chk(regFlat[7*8 +: 8] == 8'h6D, "R9 data spike ignored", regFlat[7*8 +: 8], 8'h6D);

    waitCyc(4*Q);
    done = 1;
    report();
    $finish;
  end

endmodule